// File: doc/BRIEF.md
# Converter Serial Register Slave

This block is the serial control port of a data converter. An external master selects it by pulling the chip-select line low, clocks bits in on the serial clock and, for reads, gets bits back either on the shared bidirectional data line (3-wire) or on a separate output line (4-wire). Every transaction opens with a 16-bit instruction: a direction bit, a two-bit byte count and a 13-bit register address. One or more data bytes follow, and they read or write a small local register file. The address steps after every byte. It counts down in MSB-first order and up in LSB-first order.

The serial pins are synchronized into the system clock domain, and all state lives in that domain. A configuration register at address 0x000 sets the output mode and the bit order, and it provides a soft reset. General registers are written into a staged copy. A transfer write to address 0x0FF then copies the whole staged set into the active copy, which drives the converter through `act_o`.

The serial engine is a state machine with five states. `ST_IDLE` waits while chip select is high. `ST_HEADER` shifts in 16 instruction bits. `ST_WRITE` assembles and commits data bytes. `ST_READ` loads bytes and shifts them out. `ST_DONE` ignores further clocks once the byte count is used up. The transitions are:
- IDLE→HEADER when chip select falls.
- HEADER→WRITE or HEADER→READ on the 16th bit, chosen by the direction bit.
- WRITE→DONE or READ→DONE after the last counted byte.
- Any state→IDLE whenever chip select is high.

Top module: `cspi_slave`

## Requirements
- R1: The instruction is 16 bits. In MSB-first order they arrive as: direction (1 = read), count bit 1, count bit 0, then address bits 12 down to 0. Input bits are taken on serial clock rising edges.
- R2: Count field 00, 01 and 10 give one, two and three data bytes. Bytes clocked after that, while chip select stays low, are ignored.
- R3: Count field 11 streams bytes, stepping the address each time, until chip select goes high.
- R4: In MSB-first order every byte is sent bit 7 first, and the address decrements after each data byte.
- R5: In LSB-first order the instruction is sent fully reversed (address bit 0 first, direction bit last), data bytes are sent bit 0 first, and the address increments after each byte.
- R6: Register 0x000 holds three bits:
  - bit 7 selects 4-wire output;
  - bit 6 selects LSB-first order;
  - bit 5 is soft reset.
  Bits 0, 1 and 2 mirror bits 7, 6 and 5. A write sets each function if either its bit or its mirror bit is 1. A read returns both copies. A new mode takes effect at the next chip-select fall.
- R7: Writing 1 to register 0x000 bit 5 (or bit 2) returns the configuration, every staged register and every active register to 0x00. The reset bit then reads back 0.
- R8: Registers 0x008 to 0x00F are staged: reads return the staged value. `act_o` (byte i is the active copy of address 0x008+i) changes only when bit 0 of a byte written to 0x0FF is 1, and then it takes the whole staged set. Register 0x0FF reads back 0.
- R9: In 3-wire mode a read drives `sdio_oe` only after the instruction, through the data phase. Read data changes on serial clock falling edges. Both enables return low when chip select goes high.
- R10: In 4-wire mode read data appears on `sdo_o` with `sdo_oe` high, and `sdio_oe` stays low.
- R11: Chip select going high in mid-byte or mid-instruction aborts the transaction without committing the partial byte. The next transaction starts with a fresh instruction.
- R12: Addresses outside 0x000, 0x008–0x00F and 0x0FF read as 0x00, and writes to them have no effect.
- R13: After reset both output enables are low and `act_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csb | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the master |
| sdio_i | input | 1 | Input value of the bidirectional data pad |
| sdio_o | output | 1 | Output value for the bidirectional data pad |
| sdio_oe | output | 1 | Output enable for the bidirectional data pad |
| sdo_o | output | 1 | Separate serial data output (4-wire) |
| sdo_oe | output | 1 | Output enable for the separate data output |
| act_o | output | NREG*8 | Active register set, byte i for address 0x008+i |

## Verification
The assertions take for granted that the serial clock is slow against the system clock: each serial clock level lasts at least SYNC_STAGES+2 system cycles. They also assume that chip select has been low for at least as long before the first rising serial clock edge, and that the data line is steady around each rising edge. The bench keeps every serial clock phase at six system cycles. It changes data only while the serial clock is low, and it waits several phases after each chip-select edge, so no synchronized edge is ever lost or merged.

// File: rtl/cspi_pkg.sv
package cspi_pkg;

    localparam int HDR_BITS = 16;
    localparam int ADDR_W   = 13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_WRITE,
        ST_READ,
        ST_DONE
    } cspi_state_e;

    typedef struct packed {
        logic sdo_en;
        logic lsb_first;
    } cspi_cfg_t;

    // Readback keeps a mirrored copy so the byte reads the same in either order.
    function automatic logic [7:0] cfg_readback(cspi_cfg_t c);
        return {c.sdo_en, c.lsb_first, 1'b0, 2'b00, 1'b0, c.lsb_first, c.sdo_en};
    endfunction

endpackage

// File: rtl/cspi_sync.sv
module cspi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csb_i,
    input  logic sclk_i,
    input  logic din_i,
    output logic csb_s,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic din_s
);

    // bit 2 = chip select, bit 1 = serial clock, bit 0 = data
    logic [STAGES-1:0][2:0] pipe_q;
    logic                   sclk_d_q;
    logic                   sclk_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q   <= {STAGES{3'b100}};
            sclk_d_q <= 1'b0;
        end else begin
            pipe_q[0] <= {csb_i, sclk_i, din_i};
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
            sclk_d_q <= pipe_q[STAGES-1][1];
        end
    end

    assign csb_s     = pipe_q[STAGES-1][2];
    assign sclk_s    = pipe_q[STAGES-1][1];
    assign din_s     = pipe_q[STAGES-1][0];
    assign sclk_rise = sclk_s & ~sclk_d_q;
    assign sclk_fall = ~sclk_s & sclk_d_q;

endmodule

// File: rtl/cspi_regs.sv
module cspi_regs
    import cspi_pkg::*;
#(
    parameter int NREG      = 8,
    parameter int GP_BASE   = 8,
    parameter int XFER_ADDR = 255
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [7:0]          rd_data,
    output cspi_cfg_t           cfg,
    output logic [NREG*8-1:0]   act_o
);

    localparam logic [ADDR_W-1:0] CFG_ADDR = '0;
    localparam logic [ADDR_W-1:0] XFR_ADDR = ADDR_W'(XFER_ADDR);

    cspi_cfg_t           cfg_q;
    logic                hit_cfg;
    logic                soft_rst;
    logic                xfer;
    logic [NREG*8-1:0]   stg_flat;

    assign hit_cfg  = wr_en && (wr_addr == CFG_ADDR);
    assign soft_rst = hit_cfg && (wr_data[5] | wr_data[2]);
    assign xfer     = wr_en && (wr_addr == XFR_ADDR) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (soft_rst) begin
            cfg_q <= '0;
        end else if (hit_cfg) begin
            cfg_q.sdo_en    <= wr_data[7] | wr_data[0];
            cfg_q.lsb_first <= wr_data[6] | wr_data[1];
        end
    end

    assign cfg = cfg_q;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [7:0] stg_q;
        logic [7:0] act_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q <= '0;
                act_q <= '0;
            end else begin
                if (soft_rst) begin
                    stg_q <= '0;
                end else if (wr_en && (wr_addr == ADDR_W'(GP_BASE + i))) begin
                    stg_q <= wr_data;
                end
                if (soft_rst) begin
                    act_q <= '0;
                end else if (xfer) begin
                    act_q <= stg_q;
                end
            end
        end

        assign stg_flat[i*8 +: 8] = stg_q;
        assign act_o[i*8 +: 8]    = act_q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == CFG_ADDR) begin
            rd_data = cfg_readback(cfg_q);
        end
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == ADDR_W'(GP_BASE + i)) begin
                rd_data = stg_flat[i*8 +: 8];
            end
        end
    end

    // R8: a transfer copies the staged set, nothing else moves the active set
    assert_xfer_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (act_o == $past(stg_flat)));
    assert_act_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && !soft_rst) |=> $stable(act_o));
    // R7: soft reset clears configuration and active registers
    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cfg_q == '0 && act_o == '0));

endmodule

// File: rtl/cspi_engine.sv
module cspi_engine
    import cspi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csb_s,
    input  logic                sclk_rise,
    input  logic                sclk_fall,
    input  logic                din_s,
    input  cspi_cfg_t           cfg,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [7:0]          wr_data,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic [7:0]          rd_data,
    output logic                sdio_o,
    output logic                sdio_oe,
    output logic                sdo_o,
    output logic                sdo_oe
);

    localparam logic [3:0] HDR_LAST  = 4'(HDR_BITS - 1);
    localparam logic [3:0] BYTE_LAST = 4'd7;

    cspi_state_e           state_q, state_d;
    logic [3:0]            bit_cnt_q;
    logic [HDR_BITS-1:0]   hdr_q, hdr_next;
    logic [7:0]            rx_q, rx_next;
    logic [7:0]            tx_q;
    logic [ADDR_W-1:0]     addr_q, addr_step;
    logic [1:0]            left_q;
    logic                  stream_q;
    logic                  lsb_q;
    logic                  four_q;
    logic                  drive_q;
    logic                  load_q;
    logic                  out_q;
    logic                  hdr_done;
    logic                  byte_done;
    logic                  last_byte;
    logic                  in_data;

    assign hdr_next  = lsb_q ? {din_s, hdr_q[HDR_BITS-1:1]} : {hdr_q[HDR_BITS-2:0], din_s};
    assign rx_next   = lsb_q ? {din_s, rx_q[7:1]} : {rx_q[6:0], din_s};
    assign addr_step = lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
    assign in_data   = (state_q == ST_WRITE) || (state_q == ST_READ);
    assign hdr_done  = (state_q == ST_HEADER) && sclk_rise && (bit_cnt_q == HDR_LAST);
    assign byte_done = in_data && sclk_rise && (bit_cnt_q == BYTE_LAST);
    assign last_byte = !stream_q && (left_q == 2'd0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (csb_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_HEADER;
                ST_HEADER: if (hdr_done) state_d = hdr_next[HDR_BITS-1] ? ST_READ : ST_WRITE;
                ST_WRITE:  if (byte_done && last_byte) state_d = ST_DONE;
                ST_READ:   if (byte_done && last_byte) state_d = ST_DONE;
                ST_DONE:   state_d = ST_DONE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            hdr_q     <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            addr_q    <= '0;
            left_q    <= '0;
            stream_q  <= 1'b0;
            lsb_q     <= 1'b0;
            four_q    <= 1'b0;
            drive_q   <= 1'b0;
            load_q    <= 1'b0;
            out_q     <= 1'b0;
        end else if (csb_s) begin
            bit_cnt_q <= '0;
            drive_q   <= 1'b0;
            load_q    <= 1'b0;
            out_q     <= 1'b0;
            lsb_q     <= cfg.lsb_first;
            four_q    <= cfg.sdo_en;
        end else begin
            load_q <= 1'b0;
            if (load_q) begin
                tx_q <= rd_data;
            end
            if (sclk_rise && (state_q == ST_HEADER || in_data)) begin
                bit_cnt_q <= (hdr_done || byte_done) ? 4'd0 : bit_cnt_q + 4'd1;
            end
            if (sclk_rise && state_q == ST_HEADER) begin
                hdr_q <= hdr_next;
                if (hdr_done) begin
                    addr_q   <= hdr_next[ADDR_W-1:0];
                    left_q   <= hdr_next[HDR_BITS-2:HDR_BITS-3];
                    stream_q <= &hdr_next[HDR_BITS-2:HDR_BITS-3];
                    if (hdr_next[HDR_BITS-1]) begin
                        drive_q <= 1'b1;
                        load_q  <= 1'b1;
                    end
                end
            end
            if (sclk_rise && state_q == ST_WRITE) begin
                rx_q <= rx_next;
            end
            if (byte_done) begin
                addr_q <= addr_step;
                if (!stream_q && left_q != 2'd0) begin
                    left_q <= left_q - 2'd1;
                end
                if (state_q == ST_READ && !last_byte) begin
                    load_q <= 1'b1;
                end
            end
            if (sclk_fall && state_q == ST_READ) begin
                out_q <= lsb_q ? tx_q[0] : tx_q[7];
                tx_q  <= lsb_q ? {1'b0, tx_q[7:1]} : {tx_q[6:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        wr_en   = (state_q == ST_WRITE) && byte_done;
        wr_addr = addr_q;
        wr_data = rx_next;
        rd_addr = addr_q;
        sdio_o  = out_q;
        sdo_o   = out_q;
        sdio_oe = drive_q && !four_q;
        sdo_oe  = drive_q && four_q;
    end

    // R9: both drivers are released once chip select is seen high
    assert_hiz_after_csb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        csb_s |=> (!sdio_oe && !sdo_oe));
    // R10: never both pads driven
    assert_single_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sdio_oe, sdo_oe}));
    // R11: nothing commits while deselected
    assert_no_write_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !csb_s);
    // R2: data phase bit counter stays within a byte
    assert_byte_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_data |-> (bit_cnt_q <= BYTE_LAST));
    // R1: no output is driven while the instruction is still arriving
    assert_no_drive_in_header_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HEADER) |-> (!sdio_oe && !sdo_oe));

endmodule

// File: rtl/cspi_slave.sv
module cspi_slave
    import cspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NREG        = 8,
    parameter int GP_BASE     = 8,
    parameter int XFER_ADDR   = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csb,
    input  logic              sclk,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo_o,
    output logic              sdo_oe,
    output logic [NREG*8-1:0] act_o
);

    logic                csb_s;
    logic                sclk_rise;
    logic                sclk_fall;
    logic                din_s;
    cspi_cfg_t           cfg;
    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [7:0]          wr_data;
    logic [ADDR_W-1:0]   rd_addr;
    logic [7:0]          rd_data;

    cspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .csb_i     (csb),
        .sclk_i    (sclk),
        .din_i     (sdio_i),
        .csb_s     (csb_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din_s     (din_s)
    );

    cspi_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .csb_s     (csb_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din_s     (din_s),
        .cfg       (cfg),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .sdio_o    (sdio_o),
        .sdio_oe   (sdio_oe),
        .sdo_o     (sdo_o),
        .sdo_oe    (sdo_oe)
    );

    cspi_regs #(
        .NREG      (NREG),
        .GP_BASE   (GP_BASE),
        .XFER_ADDR (XFER_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg     (cfg),
        .act_o   (act_o)
    );

endmodule

// File: tb/cspi_slave_test.sv
`timescale 1ns/1ps
module cspi_slave_test;

    localparam int NREG = 8;
    localparam int HALF = 6;

    typedef struct packed {
        logic        rd;
        logic [1:0]  w;
        logic [12:0] a;
        logic [31:0] d;   // write bytes or expected read bytes, byte 0 first
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 2'd0, 13'h008, 32'h0000005A},
        '{1'b1, 2'd0, 13'h008, 32'h0000005A},
        '{1'b0, 2'd2, 13'h00D, 32'h00C3B2A1},
        '{1'b1, 2'd2, 13'h00D, 32'h00C3B2A1},
        '{1'b1, 2'd1, 13'h00C, 32'h0000C3B2},
        '{1'b0, 2'd0, 13'h123, 32'h00000077},
        '{1'b1, 2'd0, 13'h123, 32'h00000000},
        '{1'b1, 2'd0, 13'h0FF, 32'h00000000},
        '{1'b0, 2'd1, 13'h009, 32'h00002211},
        '{1'b1, 2'd1, 13'h009, 32'h00002211},
        '{1'b1, 2'd0, 13'h000, 32'h00000000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csb = 1'b1;
    logic sclk = 1'b0;
    logic sdio_i = 1'b0;
    logic sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [NREG*8-1:0] act_o;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    bit  hdr_oe_bad;
    bit  data_oe_ok;

    always #5 clk = ~clk;

    cspi_slave #(.NREG(NREG)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .csb     (csb),
        .sclk    (sclk),
        .sdio_i  (sdio_i),
        .sdio_o  (sdio_o),
        .sdio_oe (sdio_oe),
        .sdo_o   (sdo_o),
        .sdo_oe  (sdo_oe),
        .act_o   (act_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic b, input bit four, output logic v,
                         output logic oe_sel, output logic oe_oth);
        @(negedge clk) sdio_i = b;
        repeat (HALF - 1) @(negedge clk);
        v      = four ? sdo_o : sdio_o;
        oe_sel = four ? sdo_oe : sdio_oe;
        oe_oth = four ? sdio_oe : sdo_oe;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic txn(input bit lsb, input bit four, input bit rd, input logic [1:0] w,
                       input logic [12:0] a, input int nbytes, input logic [31:0] wd,
                       input int cut, output logic [31:0] rdv);
        logic [15:0] h;
        logic v, oes, oeo, b;
        int sent;
        bit stop;
        int idx;
        h = {rd, w, a};
        rdv = '0;
        sent = 0;
        stop = 1'b0;
        hdr_oe_bad = 1'b0;
        data_oe_ok = 1'b1;
        @(negedge clk) csb = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            if (cut > 0 && sent == cut) stop = 1'b1;
            if (!stop) begin
                pulse(lsb ? h[i] : h[15-i], four, v, oes, oeo);
                if (oes || oeo) hdr_oe_bad = 1'b1;
                sent++;
            end
        end
        for (int k = 0; k < nbytes; k++) begin
            for (int i = 0; i < 8; i++) begin
                if (cut > 0 && sent == cut) stop = 1'b1;
                if (!stop) begin
                    idx = 8 * k + (lsb ? i : 7 - i);
                    b = rd ? 1'b0 : wd[idx];
                    pulse(b, four, v, oes, oeo);
                    if (rd) begin
                        rdv[idx] = v;
                        if (!oes || oeo) data_oe_ok = 1'b0;
                    end
                    sent++;
                end
            end
        end
        repeat (HALF) @(negedge clk);
        csb = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    function automatic logic [7:0] act_byte(input logic [NREG*8-1:0] v, input int i);
        return v[i*8 +: 8];
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R13: reset state
        check("R13 sdio_oe", 64'(sdio_oe), 64'h0);
        check("R13 sdo_oe", 64'(sdo_oe), 64'h0);
        check("R13 act_o", act_o, 64'h0);

        // table walk, MSB-first 3-wire (R1 R4 R12 R9)
        for (int n = 0; n < NVEC; n++) begin
            txn(1'b0, 1'b0, VEC[n].rd, VEC[n].w, VEC[n].a, int'(VEC[n].w) + 1, VEC[n].d, 0, r);
            if (VEC[n].rd) begin
                check($sformatf("R1/R4/R12 vector %0d", n), 64'(r), 64'(VEC[n].d));
                check($sformatf("R9 data drive vector %0d", n), 64'(data_oe_ok), 64'h1);
                check($sformatf("R9 header quiet vector %0d", n), 64'(hdr_oe_bad), 64'h0);
                check($sformatf("R9 released vector %0d", n), 64'({sdio_oe, sdo_oe}), 64'h0);
            end
        end

        // R8: staged values not yet active, transfer copies them
        check("R8 before transfer", act_o, 64'h0);
        txn(1'b0, 1'b0, 1'b0, 2'd0, 13'h0FF, 1, 32'h01, 0, r);
        check("R8 after transfer", act_o, 64'h0000A1B2C3001122);
        txn(1'b0, 1'b0, 1'b0, 2'd0, 13'h008, 1, 32'h33, 0, r);
        check("R8 active held", 64'(act_byte(act_o, 0)), 64'h22);
        txn(1'b0, 1'b0, 1'b1, 2'd0, 13'h008, 1, 32'h0, 0, r);
        check("R8 staged readback", 64'(r), 64'h33);
        txn(1'b0, 1'b0, 1'b1, 2'd0, 13'h0FF, 1, 32'h0, 0, r);
        check("R8 transfer self-clears", 64'(r), 64'h0);

        // R2: bytes past the count are ignored
        txn(1'b0, 1'b0, 1'b0, 2'd0, 13'h00A, 2, 32'h5544, 0, r);
        txn(1'b0, 1'b0, 1'b1, 2'd0, 13'h00A, 1, 32'h0, 0, r);
        check("R2 counted byte", 64'(r), 64'h44);
        txn(1'b0, 1'b0, 1'b1, 2'd0, 13'h009, 1, 32'h0, 0, r);
        check("R2 extra byte ignored", 64'(r), 64'h11);

        // R3: streaming write and read of four bytes
        txn(1'b0, 1'b0, 1'b0, 2'd3, 13'h00F, 4, 32'h04030201, 0, r);
        txn(1'b0, 1'b0, 1'b1, 2'd3, 13'h00F, 4, 32'h0, 0, r);
        check("R3 stream read", 64'(r), 64'h04030201);
        txn(1'b0, 1'b0, 1'b1, 2'd0, 13'h00C, 1, 32'h0, 0, r);
        check("R3 fourth streamed byte", 64'(r), 64'h04);

        // R11: aborts in the data byte and in the instruction
        txn(1'b0, 1'b0, 1'b0, 2'd0, 13'h00E, 1, 32'hFF, 20, r);
        txn(1'b0, 1'b0, 1'b1, 2'd0, 13'h00E, 1, 32'h0, 0, r);
        check("R11 partial byte dropped", 64'(r), 64'h02);
        txn(1'b0, 1'b0, 1'b0, 2'd0, 13'h00E, 1, 32'hFF, 7, r);
        txn(1'b0, 1'b0, 1'b1, 2'd0, 13'h00E, 1, 32'h0, 0, r);
        check("R11 fresh header after abort", 64'(r), 64'h02);

        // R6 / R5: LSB-first via the configuration register
        txn(1'b0, 1'b0, 1'b0, 2'd0, 13'h000, 1, 32'h42, 0, r);
        txn(1'b1, 1'b0, 1'b1, 2'd0, 13'h000, 1, 32'h0, 0, r);
        check("R6 mirrored readback", 64'(r), 64'h42);
        txn(1'b1, 1'b0, 1'b0, 2'd1, 13'h008, 2, 32'h0000BC9A, 0, r);
        txn(1'b1, 1'b0, 1'b1, 2'd1, 13'h008, 2, 32'h0, 0, r);
        check("R5 incrementing read", 64'(r), 64'h0000BC9A);
        txn(1'b1, 1'b0, 1'b1, 2'd0, 13'h009, 1, 32'h0, 0, r);
        check("R5 second byte at higher address", 64'(r), 64'hBC);
        txn(1'b1, 1'b0, 1'b0, 2'd0, 13'h000, 1, 32'h00, 0, r);
        txn(1'b0, 1'b0, 1'b1, 2'd0, 13'h000, 1, 32'h0, 0, r);
        check("R6 back to MSB-first", 64'(r), 64'h00);
        txn(1'b0, 1'b0, 1'b0, 2'd0, 13'h000, 1, 32'h02, 0, r);
        txn(1'b1, 1'b0, 1'b1, 2'd0, 13'h000, 1, 32'h0, 0, r);
        check("R6 mirror bit alone sets order", 64'(r), 64'h42);
        txn(1'b1, 1'b0, 1'b0, 2'd0, 13'h000, 1, 32'h00, 0, r);

        // R10: 4-wire read
        txn(1'b0, 1'b0, 1'b0, 2'd0, 13'h000, 1, 32'h81, 0, r);
        txn(1'b0, 1'b1, 1'b1, 2'd0, 13'h008, 1, 32'h0, 0, r);
        check("R10 data on separate output", 64'(r), 64'h9A);
        check("R10 only separate output driven", 64'(data_oe_ok), 64'h1);
        check("R10 released", 64'({sdio_oe, sdo_oe}), 64'h0);

        // R7: soft reset
        txn(1'b0, 1'b1, 1'b0, 2'd0, 13'h000, 1, 32'h24, 0, r);
        check("R7 active cleared", act_o, 64'h0);
        txn(1'b0, 1'b0, 1'b1, 2'd0, 13'h008, 1, 32'h0, 0, r);
        check("R7 staged cleared", 64'(r), 64'h00);
        txn(1'b0, 1'b0, 1'b1, 2'd0, 13'h000, 1, 32'h0, 0, r);
        check("R7 config cleared", 64'(r), 64'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule